// File: doc/BRIEF.md
# Reorder Buffer with Operand Bypass

This block is a circular reorder buffer. It keeps the instructions of an out-of-order core in program order from issue until retirement. Each slot holds an instruction tag, a result value, a destination identifier, a valid flag and a done flag. The issue stage claims slots one at a time. When the buffer has no free slot, the claim is refused and a stall output is raised. Execution units later deliver a result and a destination to the slot that was handed out. The oldest slot retires through the commit port as soon as it is done. Younger slots that finished early wait behind it.

Two side paths complete the block. A bypass read port lets an issuing instruction fetch a producer's finished but unretired value. If the producer has not finished, the port reports that the value is not ready. A branch-mispredict input names the slot of the branch. Every slot younger than the branch is dropped, and the allocation pointer moves back to the slot just after the branch.

For every slot, the block drives a one-cycle write strobe and a one-cycle read strobe. These let an observer follow the order in which the value fields are touched.

Top module: `retire_queue`

## Requirements
- R1: After reset the buffer is empty: commitValid is 0, allocStall is 0 and allocIdx is 0.
- R2: Each accepted allocation takes the slot shown on allocIdx in that cycle. Successive allocations take consecutive slot numbers, and slot DEPTH-1 is followed by slot 0.
- R3: While all DEPTH slots are occupied, allocReq raises allocStall in the same cycle and no slot is taken. The allocation pointer (allocIdx) does not move.
- R4: An accepted writeback stores wbValue and wbDest into slot wbIdx and marks it done. A writeback to a free slot, or to a slot that is already done, is ignored.
- R5: commitValid is high in exactly the cycles where the oldest slot is done. In those cycles it presents that slot's tag, value and destination, and the slot is freed at the next edge. A done slot that is younger than an unfinished one never retires first.
- R6: A commit and an allocation may occur in the same cycle, and both take effect.
- R7: A bypass read of a valid, done slot gives byReady=1 and that slot's value. For any other slot it gives byReady=0 and byValue=0.
- R8: A squash naming a valid slot removes every slot younger than it, and the next allocation receives the slot after the branch. A squash naming a free slot is ignored. An allocation requested in the same cycle as an accepted squash is ignored.
- R9: entryWr[i] is high exactly in the cycle in which an accepted writeback targets slot i. At most one bit is high at a time.
- R10: entryRd[i] is high in the cycle in which slot i is retired through the commit port, or is read by a bypass that returns ready data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| allocReq | input | 1 | Issue stage requests a slot |
| allocTag | input | TAG_W | Tag of the issuing instruction |
| allocIdx | output | PTR_W | Slot the next allocation receives |
| allocStall | output | 1 | Request refused, buffer full |
| wbValid | input | 1 | Writeback present |
| wbIdx | input | PTR_W | Slot being written back |
| wbValue | input | VAL_W | Result value |
| wbDest | input | DEST_W | Destination identifier |
| byReq | input | 1 | Bypass read request |
| byIdx | input | PTR_W | Slot read by the bypass |
| byReady | output | 1 | Bypass data is valid |
| byValue | output | VAL_W | Bypass data, zero when not ready |
| squashValid | input | 1 | Branch mispredict |
| squashIdx | input | PTR_W | Slot of the mispredicted branch |
| commitValid | output | 1 | Oldest slot retires this cycle |
| commitTag | output | TAG_W | Tag of retiring slot |
| commitValue | output | VAL_W | Value of retiring slot |
| commitDest | output | DEST_W | Destination of retiring slot |
| entryWr | output | DEPTH | Per-slot value-write strobe |
| entryRd | output | DEPTH | Per-slot value-read strobe |

## Verification
The main retirement path is exercised by filling every slot with data backgrounds: all zeros, all ones, half-and-half, alternating bits and nibble patterns. Results are then written back in reverse order with the oldest slot last, so a buffer that retires out of order or mixes up slots shows a wrong tag or value at the commit port. A single allocate-while-committing sequence separates a block that serializes the two from one that overlaps them. A squash in the middle of occupied slots, followed by writebacks, bypass reads and a second squash to a freed slot, separates a correct age comparison from one that drops or keeps the wrong slots.

// File: rtl/retire_queue_pkg.sv
package retire_queue_pkg;

  // Strobes from the control to the datapath, one per access kind.
  typedef struct packed {
    logic allocWe;   // tag written into the tail slot
    logic wbWe;      // value and destination written into slot wbIdx
    logic commitRe;  // head slot read for retirement
    logic bypRe;     // slot byIdx read by the bypass port
  } rqStrobes_t;

endpackage

// File: rtl/rq_control.sv
module rq_control
  import retire_queue_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             allocReq,
  input  logic             wbValid,
  input  logic [PTR_W-1:0] wbIdx,
  input  logic             byReq,
  input  logic [PTR_W-1:0] byIdx,
  input  logic             squashValid,
  input  logic [PTR_W-1:0] squashIdx,
  output rqStrobes_t       strobes,
  output logic [PTR_W-1:0] headPtr,
  output logic [PTR_W-1:0] tailPtr,
  output logic             allocStall,
  output logic             commitValid,
  output logic             byReady
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] occCount, occNext;
  logic [PTR_W-1:0] headNext, tailNext;
  logic [DEPTH-1:0] validQ, validNext, doneQ, doneNext;
  logic             isFull, allocGo, wbGo, commitGo, squashGo;
  int               branchAge;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Distance of a slot from the head, in program order.
  function automatic int ageOf(input logic [PTR_W-1:0] slot, input logic [PTR_W-1:0] hd);
    return (slot >= hd) ? int'(slot) - int'(hd) : int'(slot) + DEPTH - int'(hd);
  endfunction

  assign isFull     = (occCount == CNT_W'(DEPTH));
  assign squashGo   = squashValid && validQ[squashIdx];
  assign allocGo    = allocReq && !isFull && !squashGo;
  assign wbGo       = wbValid && validQ[wbIdx] && !doneQ[wbIdx];
  assign commitGo   = validQ[headPtr] && doneQ[headPtr];
  assign byReady    = byReq && validQ[byIdx] && doneQ[byIdx];
  assign allocStall = allocReq && isFull;
  assign commitValid = commitGo;
  assign branchAge  = ageOf(squashIdx, headPtr);

  assign strobes.allocWe  = allocGo;
  assign strobes.wbWe     = wbGo;
  assign strobes.commitRe = commitGo;
  assign strobes.bypRe    = byReady;

  always_comb begin
    validNext = validQ;
    doneNext  = doneQ;
    headNext  = commitGo ? bump(headPtr) : headPtr;
    tailNext  = tailPtr;
    occNext   = occCount + CNT_W'(allocGo) - CNT_W'(commitGo);
    if (wbGo) doneNext[wbIdx] = 1'b1;
    if (commitGo) validNext[headPtr] = 1'b0;
    if (squashGo) begin
      tailNext = bump(squashIdx);
      occNext  = CNT_W'(branchAge + 1) - CNT_W'(commitGo);
      for (int i = 0; i < DEPTH; i++) begin
        if (ageOf(PTR_W'(i), headPtr) > branchAge &&
            ageOf(PTR_W'(i), headPtr) < int'(occCount)) begin
          validNext[i] = 1'b0;
        end
      end
    end else if (allocGo) begin
      tailNext           = bump(tailPtr);
      validNext[tailPtr] = 1'b1;
      doneNext[tailPtr]  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      headPtr  <= '0;
      tailPtr  <= '0;
      occCount <= '0;
      validQ   <= '0;
      doneQ    <= '0;
    end else begin
      headPtr  <= headNext;
      tailPtr  <= tailNext;
      occCount <= occNext;
      validQ   <= validNext;
      doneQ    <= doneNext;
    end
  end

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occCount <= CNT_W'(DEPTH)); // R3
  AST_TAIL_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (isFull && allocReq && !squashValid) |=> tailPtr == $past(tailPtr)); // R3
  AST_EMPTY_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (occCount == 0) |-> !commitValid); // R5
  AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    commitValid |=> headPtr == bump($past(headPtr))); // R5
  AST_SQUASH_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    squashGo |=> tailPtr == bump($past(squashIdx))); // R8

endmodule

// File: rtl/rq_datapath.sv
module rq_datapath
  import retire_queue_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int PTR_W  = $clog2(DEPTH),
  parameter int TAG_W  = 8,
  parameter int VAL_W  = 16,
  parameter int DEST_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rqStrobes_t        strobes,
  input  logic [PTR_W-1:0]  headPtr,
  input  logic [PTR_W-1:0]  tailPtr,
  input  logic [TAG_W-1:0]  allocTag,
  input  logic [PTR_W-1:0]  wbIdx,
  input  logic [VAL_W-1:0]  wbValue,
  input  logic [DEST_W-1:0] wbDest,
  input  logic [PTR_W-1:0]  byIdx,
  output logic [TAG_W-1:0]  commitTag,
  output logic [VAL_W-1:0]  commitValue,
  output logic [DEST_W-1:0] commitDest,
  output logic [VAL_W-1:0]  byValue,
  output logic [DEPTH-1:0]  entryWr,
  output logic [DEPTH-1:0]  entryRd
);

  logic [TAG_W-1:0]  tagMem  [DEPTH];
  logic [VAL_W-1:0]  valMem  [DEPTH];
  logic [DEST_W-1:0] destMem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    assign entryWr[g] = strobes.wbWe && (wbIdx == PTR_W'(g));
    assign entryRd[g] = (strobes.commitRe && (headPtr == PTR_W'(g))) ||
                        (strobes.bypRe && (byIdx == PTR_W'(g)));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tagMem[g]  <= '0;
        valMem[g]  <= '0;
        destMem[g] <= '0;
      end else begin
        if (strobes.allocWe && (tailPtr == PTR_W'(g))) tagMem[g] <= allocTag;
        if (entryWr[g]) begin
          valMem[g]  <= wbValue;
          destMem[g] <= wbDest;
        end
      end
    end
  end

  assign commitTag   = tagMem[headPtr];
  assign commitValue = valMem[headPtr];
  assign commitDest  = destMem[headPtr];
  assign byValue     = strobes.bypRe ? valMem[byIdx] : '0;

  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(entryWr)); // R9
  AST_RD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(entryRd) <= 2); // R10
  AST_WB_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.wbWe |=> valMem[$past(wbIdx)] == $past(wbValue)); // R4

endmodule

// File: rtl/retire_queue.sv
module retire_queue
  import retire_queue_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = 8,
  parameter int VAL_W  = 16,
  parameter int DEST_W = 5,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              allocReq,
  input  logic [TAG_W-1:0]  allocTag,
  output logic [PTR_W-1:0]  allocIdx,
  output logic              allocStall,
  input  logic              wbValid,
  input  logic [PTR_W-1:0]  wbIdx,
  input  logic [VAL_W-1:0]  wbValue,
  input  logic [DEST_W-1:0] wbDest,
  input  logic              byReq,
  input  logic [PTR_W-1:0]  byIdx,
  output logic              byReady,
  output logic [VAL_W-1:0]  byValue,
  input  logic              squashValid,
  input  logic [PTR_W-1:0]  squashIdx,
  output logic              commitValid,
  output logic [TAG_W-1:0]  commitTag,
  output logic [VAL_W-1:0]  commitValue,
  output logic [DEST_W-1:0] commitDest,
  output logic [DEPTH-1:0]  entryWr,
  output logic [DEPTH-1:0]  entryRd
);

  rqStrobes_t       strobes;
  logic [PTR_W-1:0] headPtr, tailPtr;

  rq_control #(.DEPTH(DEPTH), .PTR_W(PTR_W)) uCtl (
    .clk(clk), .rst_n(rst_n), .allocReq(allocReq),
    .wbValid(wbValid), .wbIdx(wbIdx), .byReq(byReq), .byIdx(byIdx),
    .squashValid(squashValid), .squashIdx(squashIdx),
    .strobes(strobes), .headPtr(headPtr), .tailPtr(tailPtr),
    .allocStall(allocStall), .commitValid(commitValid), .byReady(byReady)
  );

  rq_datapath #(.DEPTH(DEPTH), .PTR_W(PTR_W), .TAG_W(TAG_W),
                .VAL_W(VAL_W), .DEST_W(DEST_W)) uDp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .headPtr(headPtr), .tailPtr(tailPtr), .allocTag(allocTag),
    .wbIdx(wbIdx), .wbValue(wbValue), .wbDest(wbDest), .byIdx(byIdx),
    .commitTag(commitTag), .commitValue(commitValue), .commitDest(commitDest),
    .byValue(byValue), .entryWr(entryWr), .entryRd(entryRd)
  );

  assign allocIdx = tailPtr;

  AST_BYP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !byReady |-> byValue == '0); // R7
  AST_COMMIT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    commitValid |-> entryRd != '0); // R10

endmodule

// File: tb/tb_retire_queue.sv
`timescale 1ns/1ps
module tb_retire_queue;

  localparam int DEPTH = 8, TAG_W = 8, VAL_W = 16, DEST_W = 5, PTR_W = 3;
  localparam logic [VAL_W-1:0] VALS [DEPTH] = '{16'h0000, 16'hFFFF, 16'h00FF,
    16'hFF00, 16'hAAAA, 16'h5555, 16'h0F0F, 16'hF0F0};

  logic clk = 0, rst_n = 0;
  logic allocReq = 0, wbValid = 0, byReq = 0, squashValid = 0;
  logic [TAG_W-1:0] allocTag = 0;
  logic [PTR_W-1:0] wbIdx = 0, byIdx = 0, squashIdx = 0, allocIdx;
  logic [VAL_W-1:0] wbValue = 0, byValue, commitValue;
  logic [DEST_W-1:0] wbDest = 0, commitDest;
  logic allocStall, byReady, commitValid;
  logic [TAG_W-1:0] commitTag;
  logic [DEPTH-1:0] entryWr, entryRd;
  int nChecks = 0, nFails = 0;

  always #2.5 clk = ~clk;

  retire_queue dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    allocReq = 0; wbValid = 0; byReq = 0; squashValid = 0;
  endtask

  task automatic wb(input int slot, input logic [VAL_W-1:0] v, input int d);
    wbValid = 1; wbIdx = PTR_W'(slot); wbValue = v; wbDest = DEST_W'(d);
  endtask

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1; cyc();
    // R1 reset state
    check("R1 commitValid", commitValid, 0);
    check("R1 allocIdx", allocIdx, 0);
    check("R1 allocStall", allocStall, 0);

    // Table walk: fill every slot with a data background (R2)
    for (int k = 0; k < DEPTH; k++) begin
      allocReq = 1; allocTag = TAG_W'(8'h10 + k); #1;
      check("R2 allocIdx", allocIdx, k);
      check("R2 no stall", allocStall, 0);
      cyc();
    end
    allocTag = 8'hEE; #1;
    check("R3 stall when full", allocStall, 1);
    cyc(); idle();
    check("R3 tail held / R2 wrap", allocIdx, 0);

    byReq = 1; byIdx = 3; #1;
    check("R7 not ready", byReady, 0);
    check("R7 zero value", byValue, 0);
    check("R10 no read strobe", entryRd, 0);
    cyc(); idle();

    // Results in reverse order, oldest last (R5, R9)
    for (int k = DEPTH - 1; k >= 1; k--) begin
      wb(k, VALS[k], k + 3); #1;
      check("R9 write strobe", entryWr, 32'(1 << k));
      cyc(); idle();
      check("R5 waits for oldest", commitValid, 0);
    end
    wb(2, 16'h1234, 30); #1;
    check("R4 rewrite of done slot ignored", entryWr, 0);
    cyc(); idle();
    byReq = 1; byIdx = 5; #1;
    check("R7 ready", byReady, 1);
    check("R7 value", byValue, VALS[5]);
    check("R10 bypass strobe", entryRd, 32'(1 << 5));
    cyc(); idle();
    wb(0, VALS[0], 3); cyc(); idle();

    for (int k = 0; k < DEPTH; k++) begin
      if (k == 0) allocReq = 1;
      #1;
      if (k == 0) check("R3 stall while full", allocStall, 1);
      check("R5 commitValid", commitValid, 1);
      check("R5 commitTag", commitTag, 8'h10 + k);
      check("R4 commitValue", commitValue, VALS[k]);
      check("R4 commitDest", commitDest, k + 3);
      check("R10 commit strobe", entryRd, 32'(1 << k));
      cyc(); idle();
    end
    check("R5 drained", commitValid, 0);

    // R6 commit and allocation in one cycle
    allocReq = 1; allocTag = 8'h40; cyc(); idle();
    wb(0, 16'h1111, 9); cyc(); idle();
    allocReq = 1; allocTag = 8'h41; #1;
    check("R6 commitValid", commitValid, 1);
    check("R6 commitTag", commitTag, 8'h40);
    check("R6 allocIdx", allocIdx, 1);
    check("R6 no stall", allocStall, 0);
    cyc(); idle();
    wb(1, 16'h2222, 10); cyc(); idle();
    check("R6 second commit", commitTag, 8'h41);
    check("R6 second commitValid", commitValid, 1);
    cyc();
    check("R6 empty again", commitValid, 0);

    // R8 squash: slots 2..6 allocated, branch at 3
    for (int k = 2; k <= 6; k++) begin
      allocReq = 1; allocTag = TAG_W'(8'h50 + k); cyc();
    end
    idle();
    squashValid = 1; squashIdx = 3; allocReq = 1; allocTag = 8'h99; cyc(); idle();
    check("R8 tail after branch", allocIdx, 4);
    wb(5, 16'hDEAD, 1); #1;
    check("R8 squashed slot not written", entryWr, 0);
    cyc(); idle();
    byReq = 1; byIdx = 5; #1;
    check("R8 squashed slot not ready", byReady, 0);
    cyc(); idle();
    squashValid = 1; squashIdx = 6; cyc(); idle();
    check("R8 squash of free slot ignored", allocIdx, 4);
    wb(2, 16'h3333, 2); cyc(); idle();
    wb(3, 16'h4444, 4); #1;
    check("R8 commit slot2 tag", commitTag, 8'h52);
    check("R8 commit slot2 value", commitValue, 16'h3333);
    cyc(); idle();
    check("R8 commit branch tag", commitTag, 8'h53);
    check("R8 commit branch value", commitValue, 16'h4444);
    cyc();
    check("R8 younger slots gone", commitValid, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule